// File: doc/BRIEF.md
# High-Voltage Pin Protection Controller

This block guards four high-voltage I/O pins: two bus pins (LIN and BSD), a bidirectional wake/signal pin (STI), and a wake pin (WU). Each pin has a short-circuit detect input. The block filters each one over time so that brief glitches are ignored. A confirmed fault turns the pin's driver off, or, in passive mode for the two bus pins, only records the fault. A thermal detect input turns off STI and WU at once. All faults, and any level changes seen on the wake inputs, go into latched status bits, and these raise a single interrupt.

Software never reaches the 8-bit configuration byte directly. It loads a data register, then issues a 3-bit command that holds a read/write flag and a 2-bit target address. The transfer completes one cycle later, while a busy flag is shown. One configuration bit is a self-clearing re-enable strobe. Writing it turns every disabled driver back on and clears the latched fault status. Another bit controls a timer that drops the WU output after a fixed time. Four configuration bits only drive enables for analog circuits outside this block. Timing comes from a tick derived from `CLK_HZ / TICK_HZ`, and every duration is counted in ticks.

Top module: `hv_pin_guard`

## Requirements
- R1: After reset, the configuration reads 0x00, all four driver enables are 1, and `irq`, `wu_out` and `busy` are 0.
- R2: `cmd_wdata[2]` = 1 means read and 0 means write; `cmd_wdata[1:0]` selects the target: 0 configuration, 1 status, 2 monitor, 3 WU control. `busy` is 1 for exactly the one cycle after `cmd_we`. At the end of that cycle, a write copies the data register into the target, and a read loads the target into the data register (`dat_rdata`).
- R3: Configuration bit 3 always reads back as 0. Every other configuration bit reads back as written.
- R4: Writing configuration bit 3 = 1 turns all four drivers back on and clears the short-circuit status bits and the thermal status bit. The interrupt then drops if no edge status is pending, even when the fault went away earlier.
- R5: A short-circuit detect counts as a fault only after it stays high for more than `FAST_FLT_TICKS` ticks on LIN, BSD or STI, or for more than `SLOW_FLT_TICKS` ticks on WU. Any low cycle restarts the count.
- R6: With configuration bit 2 = 0 (active), a confirmed fault on any pin sets that pin's status bit and turns its driver off until a re-enable. STI and WU are always handled this way.
- R7: With configuration bit 2 = 1 (passive), a confirmed LIN or BSD fault sets its status bit and raises `irq`, but that driver stays on.
- R8: Writing 1 to WU control bit 0 drives `wu_out` (while the WU driver is on). With configuration bit 1 = 0, the request clears itself after `MONO_TICKS` ticks. With bit 1 = 1, it stays on.
- R9: With configuration bit 4 = 1, any change on `wu_in` sets status bit 5 and any change on `sti_in` sets status bit 6. Monitor bits 0 and 1 show the `wu_in` and `sti_in` levels. With bit 4 = 0, no edge status is set and both monitor bits read 0.
- R10: While `thermal_det` is high, status bit 4 is set and the STI and WU drivers are off. Only a re-enable turns them back on.
- R11: The status layout is: bits 3:0 short-circuit flags (LIN, BSD, STI, WU), bit 4 thermal, bits 6:5 edge flags. `irq` is high while any of these is set. Writing the status register clears edge flags whose data bit is 1 and leaves the other flags alone. Monitor bits 5:2 show the driver enables in the order LIN, BSD, STI, WU.
- R12: Configuration bits 7, 6, 5 and 0 appear on `atten_en`, `tmon_en`, `vshort_en` and `wu_pullup_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_we | input | 1 | Command strobe |
| cmd_wdata | input | 3 | {read flag, target address} |
| dat_we | input | 1 | Data register write strobe |
| dat_wdata | input | 8 | Data register write value |
| dat_rdata | output | 8 | Data register contents |
| busy | output | 1 | Transfer in progress |
| sc_det | input | 4 | Short-circuit detects {WU, STI, BSD, LIN} |
| thermal_det | input | 1 | Thermal event detect |
| wu_in | input | 1 | WU pin input level |
| sti_in | input | 1 | STI pin input level |
| drv_en | output | 4 | Driver enables {WU, STI, BSD, LIN} |
| wu_out | output | 1 | WU output drive |
| irq | output | 1 | Interrupt |
| atten_en | output | 1 | Attenuator enable |
| tmon_en | output | 1 | Temperature monitor enable |
| vshort_en | output | 1 | Voltage channel short enable |
| wu_pullup_en | output | 1 | WU diagnostic pull-up enable |

## Verification
The hardest case to reach is the filter threshold: a fault must be rejected when it lasts just under the limit and confirmed when it lasts just over it, while the tick phase drifts against the detect pulse. The bench shortens every tick count through parameters. It then applies random short pulses on the fast pins, whose length cannot reach the required number of ticks in any phase. These are followed by directed long pulses, first on a fast pin and then on the WU pin, around the WU pin's longer limit. Re-enables issued after the fault has gone check that the stale fault state and the interrupt are cleared.

// File: rtl/hvg_pkg.sv
package hvg_pkg;
  localparam int NPIN    = 4;
  localparam int PIN_LIN = 0;
  localparam int PIN_BSD = 1;
  localparam int PIN_STI = 2;
  localparam int PIN_WU  = 3;

  typedef enum logic [1:0] {
    TGT_CFG  = 2'd0,
    TGT_STAT = 2'd1,
    TGT_MON  = 2'd2,
    TGT_WU   = 2'd3
  } hvg_tgt_e;

  // configuration bit positions
  localparam int CB_REEN    = 3;
  localparam int CB_PASSIVE = 2;
  localparam int CB_MONOOFF = 1;
  localparam int CB_EDGE    = 4;
endpackage

// File: rtl/hvg_tick.sv
module hvg_tick #(
  parameter int DIV = 20
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  logic [CW-1:0] cnt_q, cnt_d;

  assign tick = (cnt_q == CW'(DIV - 1));

  always_comb begin
    cnt_d = tick ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/hvg_fault_filter.sv
module hvg_fault_filter #(
  parameter int LIMIT = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic det,
  input  logic clr,
  output logic hit
);
  localparam int CW = $clog2(LIMIT + 2);
  localparam logic [CW-1:0] TOP = CW'(LIMIT + 1);
  logic [CW-1:0] cnt_q, cnt_d;

  assign hit = (cnt_q == TOP);

  always_comb begin
    if (clr || !det)              cnt_d = '0;
    else if (tick && cnt_q != TOP) cnt_d = cnt_q + 1'b1;
    else                          cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/hvg_monoflop.sv
module hvg_monoflop #(
  parameter int LIMIT = 1300000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic run,
  input  logic en,
  output logic expire
);
  localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  logic [CW-1:0] cnt_q, cnt_d;

  assign expire = run && en && tick && (cnt_q == CW'(LIMIT - 1));

  always_comb begin
    if (!run || !en || expire) cnt_d = '0;
    else if (tick)             cnt_d = cnt_q + 1'b1;
    else                       cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/hvg_rst_sync.sv
module hvg_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ns
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_ns = sync_q[1];
endmodule

// File: rtl/hv_pin_guard.sv
module hv_pin_guard #(
  parameter int CLK_HZ         = 20000000,
  parameter int TICK_HZ        = 1000000,
  parameter int FAST_FLT_TICKS = 20,
  parameter int SLOW_FLT_TICKS = 400,
  parameter int MONO_TICKS     = 1300000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_we,
  input  logic [2:0] cmd_wdata,
  input  logic       dat_we,
  input  logic [7:0] dat_wdata,
  output logic [7:0] dat_rdata,
  output logic       busy,
  input  logic [3:0] sc_det,
  input  logic       thermal_det,
  input  logic       wu_in,
  input  logic       sti_in,
  output logic [3:0] drv_en,
  output logic       wu_out,
  output logic       irq,
  output logic       atten_en,
  output logic       tmon_en,
  output logic       vshort_en,
  output logic       wu_pullup_en
);
  import hvg_pkg::*;

  localparam int DIV = (CLK_HZ / TICK_HZ > 0) ? CLK_HZ / TICK_HZ : 1;

  logic rst_ns;
  logic tick;

  // registers
  logic            busy_q, busy_d;
  logic            rnw_q, rnw_d;
  hvg_tgt_e        tgt_q, tgt_d;
  logic [7:0]      dat_q, dat_d;
  logic [7:0]      cfg_q, cfg_d;
  logic            wu_req_q, wu_req_d;
  logic [NPIN-1:0] sc_q, sc_d;
  logic            th_q, th_d;
  logic [1:0]      edg_q, edg_d;
  logic [1:0]      lvl_prev_q;
  logic [NPIN-1:0] dis_q, dis_d;

  // combinational
  logic            wr_cfg, wr_stat, wr_wu, rd_xfer;
  logic            reen;
  logic [NPIN-1:0] hit;
  logic            mono_exp;
  logic [1:0]      lvl_now, edge_set, lvl_mon;
  logic [7:0]      rd_val;

  hvg_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_ns(rst_ns));

  hvg_tick #(.DIV(DIV)) u_tick (.clk(clk), .rst_n(rst_ns), .tick(tick));

  for (genvar i = 0; i < NPIN; i++) begin : g_flt
    hvg_fault_filter #(
      .LIMIT((i == PIN_WU) ? SLOW_FLT_TICKS : FAST_FLT_TICKS)
    ) u_flt (
      .clk(clk), .rst_n(rst_ns), .tick(tick),
      .det(sc_det[i]), .clr(reen), .hit(hit[i])
    );
  end

  hvg_monoflop #(.LIMIT(MONO_TICKS)) u_mono (
    .clk(clk), .rst_n(rst_ns), .tick(tick),
    .run(wu_req_q), .en(!cfg_q[CB_MONOOFF]), .expire(mono_exp)
  );

  // transfer decode
  always_comb begin
    wr_cfg  = busy_q && !rnw_q && (tgt_q == TGT_CFG);
    wr_stat = busy_q && !rnw_q && (tgt_q == TGT_STAT);
    wr_wu   = busy_q && !rnw_q && (tgt_q == TGT_WU);
    rd_xfer = busy_q && rnw_q;
    reen    = wr_cfg && dat_q[CB_REEN];
  end

  // read mux
  always_comb begin
    lvl_now = {sti_in, wu_in};
    lvl_mon = cfg_q[CB_EDGE] ? lvl_now : 2'b00;
    case (tgt_q)
      TGT_CFG:  rd_val = cfg_q;
      TGT_STAT: rd_val = {1'b0, edg_q, th_q, sc_q};
      TGT_MON:  rd_val = {2'b00, ~dis_q, lvl_mon};
      default:  rd_val = {7'b0, wu_req_q};
    endcase
  end

  // next state
  always_comb begin
    busy_d = cmd_we;
    rnw_d  = cmd_we ? cmd_wdata[2] : rnw_q;
    tgt_d  = cmd_we ? hvg_tgt_e'(cmd_wdata[1:0]) : tgt_q;

    if (rd_xfer)     dat_d = rd_val;
    else if (dat_we) dat_d = dat_wdata;
    else             dat_d = dat_q;

    if (wr_cfg) cfg_d = {dat_q[7:4], 1'b0, dat_q[2:0]};
    else        cfg_d = cfg_q;

    if (wr_wu)         wu_req_d = dat_q[0];
    else if (mono_exp) wu_req_d = 1'b0;
    else               wu_req_d = wu_req_q;

    edge_set = cfg_q[CB_EDGE] ? (lvl_now ^ lvl_prev_q) : 2'b00;
    edg_d    = (edg_q & ~(wr_stat ? dat_q[6:5] : 2'b00)) | edge_set;

    th_d = (reen ? 1'b0 : th_q) | thermal_det;

    for (int i = 0; i < NPIN; i++) begin
      sc_d[i]  = (reen ? 1'b0 : sc_q[i]) | (hit[i] && !reen);
      dis_d[i] = (reen ? 1'b0 : dis_q[i])
               | (hit[i] && !reen && ((i >= PIN_STI) || !cfg_q[CB_PASSIVE]));
    end
    dis_d[PIN_STI] = dis_d[PIN_STI] | thermal_det;
    dis_d[PIN_WU]  = dis_d[PIN_WU]  | thermal_det;
  end

  // registers
  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      busy_q     <= 1'b0;
      rnw_q      <= 1'b0;
      tgt_q      <= TGT_CFG;
      dat_q      <= '0;
      cfg_q      <= '0;
      wu_req_q   <= 1'b0;
      sc_q       <= '0;
      th_q       <= 1'b0;
      edg_q      <= '0;
      lvl_prev_q <= '0;
      dis_q      <= '0;
    end else begin
      busy_q     <= busy_d;
      rnw_q      <= rnw_d;
      tgt_q      <= tgt_d;
      dat_q      <= dat_d;
      cfg_q      <= cfg_d;
      wu_req_q   <= wu_req_d;
      sc_q       <= sc_d;
      th_q       <= th_d;
      edg_q      <= edg_d;
      lvl_prev_q <= lvl_now;
      dis_q      <= dis_d;
    end
  end

  assign dat_rdata    = dat_q;
  assign busy         = busy_q;
  assign drv_en       = ~dis_q;
  assign wu_out       = wu_req_q && !dis_q[PIN_WU];
  assign irq          = |{sc_q, th_q, edg_q};
  assign atten_en     = cfg_q[7];
  assign tmon_en      = cfg_q[6];
  assign vshort_en    = cfg_q[5];
  assign wu_pullup_en = cfg_q[0];
endmodule

// File: rtl/hvg_checker.sv
module hvg_checker (
  input logic       clk,
  input logic       rst_ns,
  input logic       cmd_we,
  input logic       busy,
  input logic [3:0] drv_en,
  input logic [7:0] cfg_q,
  input logic       reen,
  input logic [3:0] sc_q,
  input logic       thermal_det
);
  // R2: busy lasts one cycle and follows a command
  a_r2_busy_single: assert property (@(posedge clk) disable iff (!rst_ns)
    busy |=> !busy);
  a_r2_busy_cause: assert property (@(posedge clk) disable iff (!rst_ns)
    $rose(busy) |-> $past(cmd_we));
  // R4: re-enable restores the bus drivers and clears fault flags
  a_r4_reenable: assert property (@(posedge clk) disable iff (!rst_ns)
    reen |=> (drv_en[1:0] == 2'b11) && (sc_q == 4'b0000));
  // R6: active mode turns the faulty driver off
  a_r6_active_off: assert property (@(posedge clk) disable iff (!rst_ns)
    ($rose(sc_q[0]) && !$past(cfg_q[2])) |-> !drv_en[0]);
  // R7: passive mode keeps the driver on
  a_r7_passive_on: assert property (@(posedge clk) disable iff (!rst_ns)
    ($rose(sc_q[1]) && $past(cfg_q[2])) |-> drv_en[1]);
  // R10: thermal event disables STI and WU
  a_r10_thermal_off: assert property (@(posedge clk) disable iff (!rst_ns)
    thermal_det |=> (drv_en[3:2] == 2'b00));
endmodule

bind hv_pin_guard hvg_checker chk_i (
  .clk(clk), .rst_ns(rst_ns), .cmd_we(cmd_we), .busy(busy),
  .drv_en(drv_en), .cfg_q(cfg_q), .reen(reen), .sc_q(sc_q),
  .thermal_det(thermal_det)
);

// File: tb/hv_pin_guard_tb_top.sv
module hv_pin_guard_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       cmd_we;
  logic [2:0] cmd_wdata;
  logic       dat_we;
  logic [7:0] dat_wdata;
  logic [7:0] dat_rdata;
  logic       busy;
  logic [3:0] sc_det;
  logic       thermal_det, wu_in, sti_in;
  logic [3:0] drv_en;
  logic       wu_out, irq, atten_en, tmon_en, vshort_en, wu_pullup_en;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  hv_pin_guard #(
    .CLK_HZ(2), .TICK_HZ(1), .FAST_FLT_TICKS(4),
    .SLOW_FLT_TICKS(10), .MONO_TICKS(20)
  ) dut_i (.*);

  function automatic logic [7:0] exp_cfg(input logic [7:0] d);
    return d & 8'hF7;
  endfunction

  function automatic logic [3:0] exp_ana(input logic [7:0] d);
    return {d[7], d[6], d[5], d[0]};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic hv_cmd(input logic [2:0] c);
    @(negedge clk);
    cmd_we = 1'b1; cmd_wdata = c;
    @(negedge clk);
    cmd_we = 1'b0;
    chk("R2 busy set", busy, 1);
    @(negedge clk);
    chk("R2 busy clear", busy, 0);
  endtask

  task automatic hv_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    dat_we = 1'b1; dat_wdata = d;
    @(negedge clk);
    dat_we = 1'b0;
    hv_cmd({1'b0, a});
  endtask

  task automatic hv_read(input logic [1:0] a, output logic [7:0] v);
    hv_cmd({1'b1, a});
    v = dat_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic report;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finish");
      report();
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    logic [7:0] d;
    int unsigned r;
    rst_n = 1'b0; cmd_we = 0; cmd_wdata = 0; dat_we = 0; dat_wdata = 0;
    sc_det = 0; thermal_det = 0; wu_in = 0; sti_in = 0;
    r = $urandom(32'd4242);
    idle(3);
    rst_n = 1'b1;
    idle(4);

    // R1 reset state
    chk("R1 drv_en", drv_en, 4'hF);
    chk("R1 irq", irq, 0);
    chk("R1 wu_out", wu_out, 0);
    chk("R1 busy", busy, 0);
    hv_read(2'd0, v);
    chk("R1 cfg", v, 8'h00);

    // R2 R3 R12 random configuration round trips
    for (int k = 0; k < 16; k++) begin
      d = 8'($urandom());
      hv_write(2'd0, d);
      chk("R12 analog enables", {atten_en, tmon_en, vshort_en, wu_pullup_en}, exp_ana(d));
      hv_read(2'd0, v);
      chk("R3 cfg readback", v, exp_cfg(d));
    end
    hv_write(2'd0, 8'h08);
    hv_read(2'd0, v);
    chk("R3 self-clear", v, 8'h00);

    // R5 short pulses on fast pins are rejected
    for (int k = 0; k < 8; k++) begin
      int pin;
      int len;
      pin = int'($urandom() % 3);
      len = 1 + int'($urandom() % 6);
      @(negedge clk); sc_det[pin] = 1'b1;
      idle(len);
      sc_det[pin] = 1'b0;
      idle(2);
    end
    hv_read(2'd1, v);
    chk("R5 short pulses ignored", v[3:0], 4'h0);
    chk("R5 drivers still on", drv_en, 4'hF);

    // R6 active mode long fault on LIN
    @(negedge clk); sc_det[0] = 1'b1;
    idle(16);
    sc_det[0] = 1'b0;
    idle(2);
    chk("R6 LIN disabled", drv_en, 4'hE);
    chk("R6 irq", irq, 1);
    hv_read(2'd2, v);
    chk("R11 monitor drivers", v[5:2], 4'hE);
    // R4 re-enable after the fault has gone
    hv_write(2'd0, 8'h08);
    chk("R4 drivers restored", drv_en, 4'hF);
    chk("R4 irq cleared", irq, 0);
    hv_read(2'd1, v);
    chk("R4 status cleared", v, 8'h00);

    // R5 WU threshold: below then above
    @(negedge clk); sc_det[3] = 1'b1;
    idle(16);
    sc_det[3] = 1'b0;
    idle(2);
    chk("R5 WU below limit", drv_en, 4'hF);
    @(negedge clk); sc_det[3] = 1'b1;
    idle(30);
    sc_det[3] = 1'b0;
    idle(2);
    chk("R5 WU above limit", drv_en, 4'h7);
    hv_read(2'd1, v);
    chk("R11 WU flag bit3", v, 8'h08);
    hv_write(2'd0, 8'h08);

    // R7 passive mode on BSD
    hv_write(2'd0, 8'h04);
    @(negedge clk); sc_det[1] = 1'b1;
    idle(16);
    sc_det[1] = 1'b0;
    idle(2);
    chk("R7 BSD stays on", drv_en, 4'hF);
    chk("R7 irq", irq, 1);
    hv_read(2'd1, v);
    chk("R7 BSD flag", v, 8'h02);
    hv_write(2'd0, 8'h0C);
    chk("R4 irq after passive", irq, 0);

    // R8 monoflop
    hv_write(2'd0, 8'h00);
    hv_write(2'd3, 8'h01);
    chk("R8 wu asserted", wu_out, 1);
    idle(10);
    chk("R8 wu before timeout", wu_out, 1);
    idle(60);
    chk("R8 wu timed out", wu_out, 0);
    hv_write(2'd0, 8'h02);
    hv_write(2'd3, 8'h01);
    idle(80);
    chk("R8 timeout disabled", wu_out, 1);
    hv_write(2'd3, 8'h00);
    chk("R8 wu released", wu_out, 0);

    // R9 edges disabled
    hv_write(2'd0, 8'h00);
    @(negedge clk); wu_in = 1'b1; sti_in = 1'b1;
    idle(2);
    chk("R9 no edge when off", irq, 0);
    hv_read(2'd2, v);
    chk("R9 monitor levels masked", v[1:0], 2'b00);
    // R9 edges enabled
    hv_write(2'd0, 8'h10);
    hv_read(2'd2, v);
    chk("R9 monitor levels", v[1:0], 2'b11);
    @(negedge clk); wu_in = 1'b0;
    idle(2);
    chk("R9 WU edge irq", irq, 1);
    @(negedge clk); sti_in = 1'b0;
    idle(2);
    hv_read(2'd1, v);
    chk("R9 edge flags", v, 8'h60);
    // R11 W1C of one edge flag only
    hv_write(2'd1, 8'h20);
    hv_read(2'd1, v);
    chk("R11 W1C WU edge", v, 8'h40);
    hv_write(2'd1, 8'h5F);
    chk("R11 irq after W1C", irq, 0);
    hv_write(2'd0, 8'h00);

    // R10 thermal
    @(negedge clk); thermal_det = 1'b1;
    @(negedge clk); thermal_det = 1'b0;
    idle(3);
    chk("R10 STI WU off", drv_en, 4'h3);
    hv_read(2'd1, v);
    chk("R10 thermal flag", v, 8'h10);
    hv_write(2'd0, 8'h08);
    chk("R10 re-enabled", drv_en, 4'hF);
    chk("R10 irq clear", irq, 0);

    done = 1'b1;
    report();
    $finish;
  end
endmodule